// File: doc/BRIEF.md
# Pause Frame Insertion Generator

This block sits in a transmit path between a client packet source and the downstream byte stream. Software describes a flow-control pause frame through a small set of write-only registers: a control word that carries the destination kind and the pause time, and a destination address split over a low and a high word. Writing any value to a dedicated trigger register asks for one pause frame.

The block does not break into a packet. It waits until the client is between packets, then blocks the client for one capture cycle. In that cycle it takes a copy of the registers. It then emits a padded MAC control frame: destination, source, the control EtherType, the pause opcode, the pause time and zero padding. When the last byte has been accepted, client traffic resumes. The FCS and everything below it are added further down the path.

Both streams are byte wide. Each beat carries valid, ready, a start marker and an end marker. When no frame is being inserted, client beats pass straight through without combinational change.

Top module: `pause_frame_inserter`

## Requirements
- R1: With no insertion pending or active, the output valid, data, start and end follow the client inputs, and the client ready follows the output ready.
- R2: A write of any data to offset 3 queues one pause frame. Further trigger writes that arrive while the request is still waiting for its capture cycle are merged into that one frame.
- R3: A queued frame never starts inside a client packet. A client packet is open from its accepted start beat until its accepted end beat. While the capture cycle runs and while the frame is emitted, the client ready is held low.
- R4: Each frame is FRAME_LEN bytes long (60 by default). Start is set on byte 0 only and end is set on byte FRAME_LEN-1 only.
- R5: When control bit 16 is 0, bytes 0..5 carry the unicast destination. That destination is {high word bits 15:0, low word}, sent most significant byte first, so byte 0 is high word bits 15:8. The high word is written at offset 2 and the low word at offset 1.
- R6: When control bit 16 is 1, bytes 0..5 are 01-80-C2-00-00-01, whatever the address registers hold.
- R7: Bytes 6..11 carry the SRC_MAC parameter, most significant byte first. Bytes 12..13 are 0x88 0x08 and bytes 14..15 are 0x00 0x01.
- R8: Bytes 16..17 carry control bits 15:0, high byte first. Every byte from 18 to the end is 0x00. The control word is written at offset 0.
- R9: After reset the control word and both address words read as zero in the frame. A trigger issued straight after reset therefore yields an all-zero destination and a pause time of zero.
- R10: The frame uses the register values taken in its capture cycle. Register writes made after that cycle do not change the frame in progress.
- R11: While the output ready is low during a frame, the byte, start and end on the output stay unchanged and valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register offset (0 control, 1 low word, 2 high word, 3 trigger) |
| cfg_wdata | input | 32 | Register write data |
| cli_valid | input | 1 | Client beat valid |
| cli_data | input | 8 | Client byte |
| cli_sop | input | 1 | Client start of packet |
| cli_eop | input | 1 | Client end of packet |
| cli_ready | output | 1 | Client may advance |
| tx_valid | output | 1 | Output beat valid |
| tx_data | output | 8 | Output byte |
| tx_sop | output | 1 | Output start of packet |
| tx_eop | output | 1 | Output end of packet |
| tx_ready | input | 1 | Downstream accepts the beat |

## Verification
The bench keeps FRAME_LEN at its default of 60 and register offsets at their defaults. It overrides SRC_MAC with a pattern whose bytes are all different, so a byte swapped or misplaced in the source field shows up in the output. The minimum frame length makes the zero-padding tail, bytes 18 to 59, long enough that an off-by-one in the header boundary or in end placement is visible. The single 2-bit offset field covers every register, so each write path can be driven, including the trigger while a client packet is open.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   localparam int unsigned HDR_BYTES = 18;
   localparam logic [15:0] CTRL_ETYPE = 16'h8808;
   localparam logic [15:0] PAUSE_OPC  = 16'h0001;
   localparam logic [47:0] RSVD_MCAST = 48'h0180_C200_0001;
   localparam int unsigned MIN_FRAME  = 60;

   typedef struct packed {
      logic        mcast;
      logic [15:0] ptime;
      logic [47:0] ucast_da;
   } pfg_cfg_t;
endpackage

// File: rtl/pfg_regs.sv
module pfg_regs
   import pfg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned OFS_CTRL = 0,
   parameter int unsigned OFS_DALO = 1,
   parameter int unsigned OFS_DAHI = 2,
   parameter int unsigned OFS_TRIG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output pfg_cfg_t          cfg_live,
   output logic              trig
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_DALO = ADDR_W'(OFS_DALO);
   localparam logic [ADDR_W-1:0] A_DAHI = ADDR_W'(OFS_DAHI);
   localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);

   if (OFS_CTRL >= 2**ADDR_W || OFS_DALO >= 2**ADDR_W ||
       OFS_DAHI >= 2**ADDR_W || OFS_TRIG >= 2**ADDR_W) begin : g_bad_ofs
      $error("pfg_regs: register offset does not fit ADDR_W");
   end
   if (OFS_CTRL == OFS_TRIG || OFS_DALO == OFS_TRIG ||
       OFS_DAHI == OFS_TRIG || OFS_CTRL == OFS_DALO ||
       OFS_CTRL == OFS_DAHI || OFS_DALO == OFS_DAHI) begin : g_dup_ofs
      $error("pfg_regs: register offsets must be distinct");
   end

   logic        mcast_q;
   logic [15:0] ptime_q;
   logic [31:0] dalo_q;
   logic [15:0] dahi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcast_q <= 1'b0;
         ptime_q <= '0;
         dalo_q  <= '0;
         dahi_q  <= '0;
      end else if (cfg_wr) begin
         if (cfg_addr == A_CTRL) begin
            mcast_q <= cfg_wdata[16];
            ptime_q <= cfg_wdata[15:0];
         end
         if (cfg_addr == A_DALO) dalo_q <= cfg_wdata;
         if (cfg_addr == A_DAHI) dahi_q <= cfg_wdata[15:0];
      end
   end

   assign trig = cfg_wr && (cfg_addr == A_TRIG);

   always_comb begin
      cfg_live.mcast    = mcast_q;
      cfg_live.ptime    = ptime_q;
      cfg_live.ucast_da = {dahi_q, dalo_q};
   end
endmodule

// File: rtl/pfg_builder.sv
module pfg_builder
   import pfg_pkg::*;
#(
   parameter int unsigned FRAME_LEN = 60,
   parameter logic [47:0] SRC_MAC   = 48'h0,
   parameter logic [47:0] MC_ADDR   = RSVD_MCAST,
   localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
   input  pfg_cfg_t          cfg,
   input  logic [IDX_W-1:0]  idx,
   output logic [7:0]        byte_o
);
   localparam int unsigned SLOT_W = $clog2(HDR_BYTES);
   localparam int unsigned SLOTS  = 2**SLOT_W;
   localparam logic [IDX_W-1:0] HDR_END = IDX_W'(HDR_BYTES);

   logic [47:0] da_sel;
   logic [7:0]  hdr [SLOTS];

   assign da_sel = cfg.mcast ? MC_ADDR : cfg.ucast_da;

   for (genvar g = 0; g < 6; g++) begin : g_addr
      assign hdr[g]     = da_sel[47-8*g -: 8];
      assign hdr[6 + g] = SRC_MAC[47-8*g -: 8];
   end
   assign hdr[12] = CTRL_ETYPE[15:8];
   assign hdr[13] = CTRL_ETYPE[7:0];
   assign hdr[14] = PAUSE_OPC[15:8];
   assign hdr[15] = PAUSE_OPC[7:0];
   assign hdr[16] = cfg.ptime[15:8];
   assign hdr[17] = cfg.ptime[7:0];
   for (genvar g = HDR_BYTES; g < SLOTS; g++) begin : g_fill
      assign hdr[g] = 8'h00;
   end

   assign byte_o = (idx < HDR_END) ? hdr[idx[SLOT_W-1:0]] : 8'h00;
endmodule

// File: rtl/pfg_splicer.sv
module pfg_splicer
   import pfg_pkg::*;
#(
   parameter int unsigned FRAME_LEN = 60,
   localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  pfg_cfg_t         cfg_live,
   output pfg_cfg_t         cfg_snap,
   output logic [IDX_W-1:0] idx,
   input  logic [7:0]       frame_byte,
   input  logic             cli_valid,
   input  logic [7:0]       cli_data,
   input  logic             cli_sop,
   input  logic             cli_eop,
   output logic             cli_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_sop,
   output logic             tx_eop,
   input  logic             tx_ready,
   output logic             busy,
   output logic             pend,
   output logic             in_pkt
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

   logic busy_q, pend_q, in_pkt_q;
   logic [IDX_W-1:0] idx_q;
   pfg_cfg_t snap_q;
   logic cap, cli_go, last, cli_acc;

   assign cap    = pend_q && !in_pkt_q && !busy_q;
   assign cli_go = !busy_q && !cap;
   assign last   = (idx_q == LAST);
   assign cli_acc = cli_valid && cli_ready;

   always_comb begin
      if (busy_q) begin
         tx_valid = 1'b1;
         tx_data  = frame_byte;
         tx_sop   = (idx_q == '0);
         tx_eop   = last;
      end else begin
         tx_valid = cli_go && cli_valid;
         tx_data  = cli_data;
         tx_sop   = cli_go && cli_sop;
         tx_eop   = cli_go && cli_eop;
      end
   end
   assign cli_ready = cli_go && tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pend_q   <= 1'b0;
         in_pkt_q <= 1'b0;
         idx_q    <= '0;
         snap_q   <= '0;
      end else begin
         pend_q <= trig || (pend_q && !cap);
         if (cap) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            snap_q <= cfg_live;
         end else if (busy_q && tx_ready) begin
            if (last) begin
               busy_q <= 1'b0;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
         if (cli_acc) begin
            if (cli_eop)      in_pkt_q <= 1'b0;
            else if (cli_sop) in_pkt_q <= 1'b1;
         end
      end
   end

   assign cfg_snap = snap_q;
   assign idx      = idx_q;
   assign busy     = busy_q;
   assign pend     = pend_q;
   assign in_pkt   = in_pkt_q;
endmodule

// File: rtl/pause_frame_inserter.sv
module pause_frame_inserter
   import pfg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned OFS_CTRL  = 0,
   parameter int unsigned OFS_DALO  = 1,
   parameter int unsigned OFS_DAHI  = 2,
   parameter int unsigned OFS_TRIG  = 3,
   parameter int unsigned FRAME_LEN = 60,
   parameter logic [47:0] SRC_MAC   = 48'h0200_0000_0001,
   parameter logic [47:0] MC_ADDR   = RSVD_MCAST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              cli_valid,
   input  logic [7:0]        cli_data,
   input  logic              cli_sop,
   input  logic              cli_eop,
   output logic              cli_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_sop,
   output logic              tx_eop,
   input  logic              tx_ready
);
   localparam int unsigned IDX_W = $clog2(FRAME_LEN);

   if (FRAME_LEN < MIN_FRAME) begin : g_short
      $error("pause_frame_inserter: FRAME_LEN below minimum frame size");
   end
   if (ADDR_W < 2) begin : g_narrow
      $error("pause_frame_inserter: ADDR_W must address four registers");
   end

   pfg_cfg_t         cfg_live, cfg_snap;
   logic             trig, busy, pend, in_pkt;
   logic [IDX_W-1:0] idx;
   logic [7:0]       frame_byte;

   pfg_regs #(
      .ADDR_W(ADDR_W), .OFS_CTRL(OFS_CTRL), .OFS_DALO(OFS_DALO),
      .OFS_DAHI(OFS_DAHI), .OFS_TRIG(OFS_TRIG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_live(cfg_live), .trig(trig)
   );

   pfg_builder #(
      .FRAME_LEN(FRAME_LEN), .SRC_MAC(SRC_MAC), .MC_ADDR(MC_ADDR)
   ) u_build (
      .cfg(cfg_snap), .idx(idx), .byte_o(frame_byte)
   );

   pfg_splicer #(.FRAME_LEN(FRAME_LEN)) u_splice (
      .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_live(cfg_live),
      .cfg_snap(cfg_snap), .idx(idx), .frame_byte(frame_byte),
      .cli_valid(cli_valid), .cli_data(cli_data), .cli_sop(cli_sop),
      .cli_eop(cli_eop), .cli_ready(cli_ready), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
      .tx_ready(tx_ready), .busy(busy), .pend(pend), .in_pkt(in_pkt)
   );
endmodule

// File: rtl/pfg_chk.sv
module pfg_chk #(
   parameter int unsigned FRAME_LEN = 60,
   localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
   input logic       clk,
   input logic       rst_n,
   input logic       trig,
   input logic       busy,
   input logic       pend,
   input logic       in_pkt,
   input logic       cli_ready,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_sop,
   input logic       tx_eop,
   input logic       tx_ready
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);
   logic [IDX_W-1:0] beats;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beats <= '0;
      else if (busy && tx_valid && tx_ready) beats <= tx_eop ? '0 : beats + 1'b1;
   end

   AST_CLIENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cli_ready); // R3
   AST_NO_MIDPKT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!in_pkt)); // R3
   AST_TRIG_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (pend || busy)); // R2
   AST_FRAME_SOP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_sop) |-> (beats == '0)); // R4
   AST_FRAME_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_ready && tx_eop) |-> (beats == LAST)); // R4
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_valid && !tx_ready) |=>
         (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop))); // R11
endmodule

bind pause_frame_inserter pfg_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .pend(pend),
   .in_pkt(in_pkt), .cli_ready(cli_ready), .tx_valid(tx_valid),
   .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_ready(tx_ready)
);

// File: tb/sim_pause_frame_inserter.sv
`timescale 1ns/1ps
module sim_pause_frame_inserter;
   localparam int FL = 60;
   localparam logic [47:0] SRC = 48'h02A1_B2C3_D4E5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic cli_valid = 1'b0, cli_sop = 1'b0, cli_eop = 1'b0;
   logic [7:0] cli_data = '0;
   logic cli_ready, tx_valid, tx_sop, tx_eop;
   logic [7:0] tx_data;
   logic tx_ready = 1'b1;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [9:0] mon_d [0:2047];
   int mon_n = 0;

   // control, low word, high word
   localparam logic [95:0] VEC [4] = '{
      {32'h0000_1234, 32'hA1B2_C3D4, 32'h0000_E5F6},
      {32'h0001_FFFF, 32'h1111_1111, 32'h2222_2222},
      {32'h0000_0000, 32'hDEAD_BEEF, 32'hFFFF_0102},
      {32'h0001_0001, 32'h0000_0000, 32'h0000_0000}
   };

   always #5 clk = ~clk;

   pause_frame_inserter #(.FRAME_LEN(FL), .SRC_MAC(SRC)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cli_valid(cli_valid), .cli_data(cli_data),
      .cli_sop(cli_sop), .cli_eop(cli_eop), .cli_ready(cli_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
      .tx_eop(tx_eop), .tx_ready(tx_ready)
   );

   always @(negedge clk) begin
      #2;
      if (rst_n && tx_valid && tx_ready && mon_n < 2048) begin
         mon_d[mon_n] = {tx_sop, tx_eop, tx_data};
         mon_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send_pkt(input int len, input logic [7:0] base);
      @(negedge clk);
      for (int i = 0; i < len; i++) begin
         cli_valid = 1'b1; cli_data = base + 8'(i);
         cli_sop = (i == 0); cli_eop = (i == len - 1);
         #1;
         while (!cli_ready) begin @(negedge clk); #1; end
         @(negedge clk);
      end
      cli_valid = 1'b0; cli_sop = 1'b0; cli_eop = 1'b0;
   endtask

   function automatic logic [7:0] exp_b(input int i, input logic [31:0] c,
                                        input logic [31:0] lo, input logic [31:0] hi);
      logic [47:0] da;
      da = c[16] ? 48'h0180_C200_0001 : {hi[15:0], lo};
      if (i < 6)   return da[47-8*i -: 8];
      if (i < 12)  return SRC[47-8*(i-6) -: 8];
      case (i)
         12: return 8'h88;
         13: return 8'h08;
         14: return 8'h00;
         15: return 8'h01;
         16: return c[15:8];
         17: return c[7:0];
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input int i, input logic m);
      if (i < 6)  return m ? "R6 dest" : "R5 dest";
      if (i < 16) return "R7 header";
      return "R8 time/pad";
   endfunction

   task automatic check_frame(input int base, input logic [31:0] c,
                              input logic [31:0] lo, input logic [31:0] hi,
                              input string what);
      for (int i = 0; i < FL; i++) begin
         logic [9:0] e;
         e = {i == 0, i == FL - 1, exp_b(i, c, lo, hi)};
         chk(mon_d[base + i] == e, {what, " R4 ", tag_of(i, c[16])},
             32'(mon_d[base + i]), 32'(e));
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int mark;
      logic [31:0] c, lo, hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(tx_valid == 1'b0, "R1 reset tx_valid", 32'(tx_valid), 0);
      chk(cli_ready == 1'b1, "R1 reset ready passthrough", 32'(cli_ready), 1);

      // R9: reset contents of registers show up in the frame
      mark = mon_n;
      wr(2'd3, 32'hCAFE_0000);
      idle(FL + 10);
      chk(mon_n - mark == FL, "R9 frame length", 32'(mon_n - mark), FL);
      check_frame(mark, 32'h0, 32'h0, 32'h0, "R9");

      // table of register settings, one frame each
      foreach (VEC[k]) begin
         {c, lo, hi} = VEC[k];
         wr(2'd0, c); wr(2'd1, lo); wr(2'd2, hi);
         mark = mon_n;
         wr(2'd3, 32'(k) ^ 32'h5A5A_5A5A);
         idle(FL + 10);
         chk(mon_n - mark == FL, "R2 one frame per trigger", 32'(mon_n - mark), FL);
         check_frame(mark, c, lo, hi, "vec");
      end

      // R1: plain pass-through of a client packet
      mark = mon_n;
      send_pkt(7, 8'h40);
      idle(4);
      chk(mon_n - mark == 7, "R1 beat count", 32'(mon_n - mark), 7);
      for (int i = 0; i < 7; i++)
         chk(mon_d[mark + i] == {i == 0, i == 6, 8'h40 + 8'(i)}, "R1 beat",
             32'(mon_d[mark + i]), 32'({i == 0, i == 6, 8'h40 + 8'(i)}));

      // R3: trigger inside a client packet waits for its end
      mark = mon_n;
      fork
         send_pkt(12, 8'h70);
         begin idle(4); wr(2'd3, 32'h1); end
      join
      idle(FL + 10);
      chk(mon_n - mark == 12 + FL, "R3 total beats", 32'(mon_n - mark), 12 + FL);
      for (int i = 0; i < 12; i++)
         chk(mon_d[mark + i][7:0] == 8'h70 + 8'(i), "R3 client first",
             32'(mon_d[mark + i]), 32'(8'h70 + 8'(i)));
      check_frame(mark + 12, c, lo, hi, "R3");

      // R2: several triggers while pending merge into one frame
      mark = mon_n;
      fork
         send_pkt(12, 8'h20);
         begin idle(3); wr(2'd3, 32'h0); wr(2'd3, 32'hFFFF_FFFF); wr(2'd3, 32'h7); end
      join
      idle(2 * FL + 20);
      chk(mon_n - mark == 12 + FL, "R2 merged triggers", 32'(mon_n - mark), 12 + FL);

      // R10: writes after capture do not alter the frame
      wr(2'd0, 32'h0000_AAAA);
      mark = mon_n;
      wr(2'd3, 32'h0);
      while (mon_n < mark + 3) @(negedge clk);
      wr(2'd0, 32'h0001_5555);
      wr(2'd1, 32'h1234_5678);
      idle(FL + 10);
      chk(mon_n - mark == FL, "R10 length", 32'(mon_n - mark), FL);
      check_frame(mark, 32'h0000_AAAA, lo, hi, "R10");

      // R11: downstream back-pressure during the frame
      mark = mon_n;
      wr(2'd3, 32'h9);
      for (int i = 0; i < 3 * FL; i++) begin
         @(negedge clk);
         tx_ready = (i % 3) != 1;
      end
      tx_ready = 1'b1;
      idle(10);
      chk(mon_n - mark == FL, "R11 length", 32'(mon_n - mark), FL);
      check_frame(mark, 32'h0001_5555, 32'h1234_5678, hi, "R11");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule